// File: doc/BRIEF.md
# Single-Line NMI Trigger Controller

This block watches one asynchronous non-maskable interrupt line and turns it into a clean, acknowledgeable interrupt request for a parent interrupt controller. The raw line passes through a synchronizer. A software-selected trigger condition (either level or either edge) is then detected on the synchronized signal, and a pending flag is latched. The request output is the registered AND of that flag and an enable bit.

Software reaches the block over a small 32-bit register bus with three registers: control, pending and enable. Reads return data combinationally from the presented address, and writes take effect at the rising clock edge on which the write strobe is high. The bus carries single register accesses and has no stream of data, so it has no back-pressure and no handshake. One parameter picks between two address maps, which differ only in where the enable register sits. The expected bring-up writes 0 to enable and then writes 1 to pending, which clears any stale request. The synchronizer and edge-history flops reset to the idle level of the line (high by default), so a quiet line raises nothing after reset.

Top module: `nmi_trigger_ctrl`

## Requirements
- R1: After reset, the control, pending and enable registers all read 0, and `irq_o` is low. Control value 0 selects level-low triggering.
- R2: The control register is at offset 0x00 and holds 32 bits that software can read back unchanged. Bits [1:0] select the trigger: 0 is level low, 1 is falling edge, 2 is level high, 3 is rising edge.
- R3: In rising-edge mode, a 0-to-1 change on `nmi_in` sets pending, readable as bit 0 of offset 0x04, three clock edges after the input change. The two earlier edges leave it clear. Pending then stays set after the line drops, until it is acknowledged. A falling change does not set it.
- R4: In falling-edge mode, a 1-to-0 change sets pending with the same three-edge latency, and a rising change does not set it.
- R5: In a level mode, pending is set on every edge at which the synchronized line is at the active level. An acknowledge while the level is still active leaves pending at 1. Once the line is inactive, pending stays 1 until it is acknowledged.
- R6: Writing a value with bit 0 set to offset 0x04 clears pending. Writing a value with bit 0 clear has no effect. A trigger detected on the same edge as the acknowledge wins.
- R7: Bit 0 of the enable register unmasks the request. The enable register is at offset 0x08 when `ALT_MAP` is 0 and at offset 0x34 when `ALT_MAP` is 1. Masking never clears pending, and unmasking later raises `irq_o`.
- R8: `irq_o` is registered. It equals the value that pending AND enable had one clock edge earlier.
- R9: Reads of any unmapped offset return 0. Writes to an unmapped offset change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| nmi_in | input | 1 | Raw asynchronous interrupt line |
| bus_addr | input | ADDR_W | Byte offset of the register access |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Interrupt request to the parent controller |

## Verification
An input change is visible in pending three rising edges later: two synchronizer stages and then the pending flop. `irq_o` follows one edge after pending or enable changes. A register write shows in read data at the negative edge that follows its strobe edge. Every stimulus is driven on a falling edge, and the bench waits that exact number of falling edges before sampling. It also samples one edge early where the latency itself is under test, for example pending still clear after two edges and `irq_o` still high on the edge where the acknowledge lands. A second instance with the alternate address map shares the bus, so one write shows the enable register being decoded in one map and ignored in the other.

// File: rtl/nmi_trig_pkg.sv
package nmi_trig_pkg;

  typedef enum logic [1:0] {
    TRIG_LVL_LOW  = 2'd0,
    TRIG_FALL     = 2'd1,
    TRIG_LVL_HIGH = 2'd2,
    TRIG_RISE     = 2'd3
  } trig_mode_e;

  localparam int CTRL_OFS  = 'h00;
  localparam int PEND_OFS  = 'h04;
  localparam int EN_OFS_A  = 'h08;
  localparam int EN_OFS_B  = 'h34;

  function automatic int enable_ofs(input bit alt_map);
    return alt_map ? EN_OFS_B : EN_OFS_A;
  endfunction

endpackage

// File: rtl/nmi_sync.sv
module nmi_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] stage_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage_q[i] <= RST_VAL;
        else     stage_q[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage_q[i] <= RST_VAL;
        else     stage_q[i] <= stage_q[i-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/nmi_detect.sv
module nmi_detect
  import nmi_trig_pkg::*;
#(
  parameter bit RST_VAL = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       smp,
  input  trig_mode_e mode,
  output logic       hit
);

  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= RST_VAL;
    else     prev_q <= smp;
  end

  always_comb begin
    unique case (mode)
      TRIG_LVL_LOW:  hit = ~smp;
      TRIG_FALL:     hit = prev_q & ~smp;
      TRIG_LVL_HIGH: hit = smp;
      TRIG_RISE:     hit = smp & ~prev_q;
      default:       hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/nmi_regs.sv
module nmi_regs
  import nmi_trig_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter bit ALT_MAP = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              hit,
  output trig_mode_e        mode,
  output logic [DATA_W-1:0] rdata,
  output logic              pend,
  output logic              en,
  output logic              ack,
  output logic              irq
);

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_OFS);
  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(PEND_OFS);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(enable_ofs(ALT_MAP));

  logic [DATA_W-1:0] ctrl_q;
  logic              pend_q;
  logic              en_q;
  logic              irq_q;

  assign ack = we && (addr == A_PEND) && wdata[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      en_q   <= 1'b0;
      pend_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (we && addr == A_CTRL) ctrl_q <= wdata;
      if (we && addr == A_EN)   en_q   <= wdata[0];
      if (hit)      pend_q <= 1'b1;
      else if (ack) pend_q <= 1'b0;
      irq_q <= pend_q & en_q;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == A_CTRL)      rdata    = ctrl_q;
    else if (addr == A_PEND) rdata[0] = pend_q;
    else if (addr == A_EN)   rdata[0] = en_q;
  end

  assign mode = trig_mode_e'(ctrl_q[1:0]);
  assign pend = pend_q;
  assign en   = en_q;
  assign irq  = irq_q;

endmodule

// File: rtl/nmi_trigger_ctrl.sv
module nmi_trigger_ctrl
  import nmi_trig_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2,
  parameter bit ALT_MAP     = 1'b0,
  parameter bit IDLE_LEVEL  = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              nmi_in,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o
);

  logic       line_s;
  logic       det_hit;
  trig_mode_e trig_mode;
  logic       pend_q;
  logic       en_q;
  logic       ack_pulse;

  nmi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(IDLE_LEVEL)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (nmi_in),
    .q   (line_s)
  );

  nmi_detect #(.RST_VAL(IDLE_LEVEL)) u_detect (
    .clk  (clk),
    .rst  (rst),
    .smp  (line_s),
    .mode (trig_mode),
    .hit  (det_hit)
  );

  nmi_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ALT_MAP(ALT_MAP)) u_regs (
    .clk   (clk),
    .rst   (rst),
    .addr  (bus_addr),
    .we    (bus_we),
    .wdata (bus_wdata),
    .hit   (det_hit),
    .mode  (trig_mode),
    .rdata (bus_rdata),
    .pend  (pend_q),
    .en    (en_q),
    .ack   (ack_pulse),
    .irq   (irq_o)
  );

endmodule

// File: rtl/nmi_trigger_ctrl_chk.sv
module nmi_trigger_ctrl_chk
  import nmi_trig_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter bit ALT_MAP = 1'b0
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              irq_o,
  input logic              pend_q,
  input logic              en_q,
  input logic              det_hit,
  input logic              ack_pulse
);

  logic mapped;
  assign mapped = (bus_addr == ADDR_W'(CTRL_OFS)) ||
                  (bus_addr == ADDR_W'(PEND_OFS)) ||
                  (bus_addr == ADDR_W'(enable_ofs(ALT_MAP)));

  // R6
  ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_pulse && !det_hit) |=> !pend_q);

  // R3
  pend_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (pend_q && !ack_pulse) |=> pend_q);

  // R5
  pend_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pend_q) |-> $past(det_hit));

  // R7
  masked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> !irq_o);

  // R8
  irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> ($past(pend_q) && $past(en_q)));

  // R9
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !mapped |-> (bus_rdata == '0));

endmodule

bind nmi_trigger_ctrl nmi_trigger_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ALT_MAP(ALT_MAP)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .irq_o     (irq_o),
  .pend_q    (pend_q),
  .en_q      (en_q),
  .det_hit   (det_hit),
  .ack_pulse (ack_pulse)
);

// File: tb/sim_nmi_trigger_ctrl.sv
module sim_nmi_trigger_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          nmi_in = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] rdata0, rdata1;
  logic          irq0, irq1;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nmi_trigger_ctrl #(.ADDR_W(AW), .DATA_W(DW), .ALT_MAP(1'b0)) u0 (
    .clk(clk), .rst(rst), .nmi_in(nmi_in), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(rdata0), .irq_o(irq0)
  );

  nmi_trigger_ctrl #(.ADDR_W(AW), .DATA_W(DW), .ALT_MAP(1'b1)) u1 (
    .clk(clk), .rst(rst), .nmi_in(nmi_in), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(rdata1), .irq_o(irq1)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_we    = 1'b1;
    @(negedge clk);
    bus_we    = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] v0,
                    output logic [DW-1:0] v1);
    bus_addr = a;
    #1;
    v0 = rdata0;
    v1 = rdata1;
  endtask

  task automatic pend_is(input string req, input string what, input logic exp);
    logic [DW-1:0] v0, v1;
    rd(8'h04, v0, v1);
    chk(req, what, v0, {31'd0, exp});
  endtask

  task automatic t_reset;
    logic [DW-1:0] v0, v1;
    rd(8'h00, v0, v1); chk("R1", "ctrl after reset", v0, 32'h0);
    rd(8'h04, v0, v1); chk("R1", "pending after reset", v0, 32'h0);
    rd(8'h08, v0, v1); chk("R1", "enable after reset", v0, 32'h0);
    chk("R1", "irq after reset", {31'd0, irq0}, 32'h0);
  endtask

  task automatic t_ctrl_field;
    logic [DW-1:0] v0, v1;
    wr(8'h00, 32'hDEAD_BEE5);
    rd(8'h00, v0, v1); chk("R2", "ctrl readback", v0, 32'hDEAD_BEE5);
    wr(8'h08, 32'h0);
    wr(8'h04, 32'h1);
    pend_is("R2", "no pending after bring-up", 1'b0);
  endtask

  task automatic t_rise;
    wr(8'h00, 32'h3);
    wr(8'h08, 32'h1);
    nmi_in = 1'b0; idle(3);
    pend_is("R3", "falling change ignored in rise mode", 1'b0);
    nmi_in = 1'b1; idle(2);
    pend_is("R3", "pending clear two edges after rise", 1'b0);
    idle(1);
    pend_is("R3", "pending set three edges after rise", 1'b1);
    chk("R8", "irq not yet raised", {31'd0, irq0}, 32'h0);
    idle(1);
    chk("R8", "irq one edge after pending", {31'd0, irq0}, 32'h1);
    nmi_in = 1'b0; idle(4);
    pend_is("R3", "pending sticky after line drops", 1'b1);
    wr(8'h04, 32'h1);
    pend_is("R6", "ack clears pending", 1'b0);
    chk("R8", "irq still high on ack edge", {31'd0, irq0}, 32'h1);
    idle(1);
    chk("R8", "irq low one edge after ack", {31'd0, irq0}, 32'h0);
  endtask

  task automatic t_fall;
    wr(8'h00, 32'h1);
    nmi_in = 1'b1; idle(3);
    pend_is("R4", "rising change ignored in fall mode", 1'b0);
    nmi_in = 1'b0; idle(3);
    pend_is("R4", "falling change sets pending", 1'b1);
    wr(8'h04, 32'h0);
    pend_is("R6", "write of zero keeps pending", 1'b1);
    wr(8'h04, 32'h1);
    pend_is("R6", "ack clears pending in fall mode", 1'b0);
  endtask

  task automatic t_mask;
    wr(8'h08, 32'h0);
    nmi_in = 1'b1; idle(3);
    nmi_in = 1'b0; idle(3);
    pend_is("R7", "pending sets while masked", 1'b1);
    idle(1);
    chk("R7", "masked irq low", {31'd0, irq0}, 32'h0);
    wr(8'h08, 32'h1);
    chk("R7", "irq low on unmask edge", {31'd0, irq0}, 32'h0);
    idle(1);
    chk("R7", "irq high after unmask", {31'd0, irq0}, 32'h1);
    wr(8'h04, 32'h1);
    wr(8'h08, 32'h0);
  endtask

  task automatic t_level_high;
    wr(8'h00, 32'h2);
    idle(1);
    pend_is("R5", "inactive low line in level-high mode", 1'b0);
    nmi_in = 1'b1; idle(3);
    pend_is("R5", "level high sets pending", 1'b1);
    wr(8'h04, 32'h1);
    pend_is("R5", "ack while high is re-asserted", 1'b1);
    nmi_in = 1'b0; idle(3);
    pend_is("R5", "pending held after level drops", 1'b1);
    wr(8'h04, 32'h1);
    pend_is("R5", "ack after level drops clears", 1'b0);
  endtask

  task automatic t_level_low;
    wr(8'h00, 32'h0);
    idle(1);
    pend_is("R5", "level low active at once", 1'b1);
    wr(8'h04, 32'h1);
    pend_is("R5", "ack while low is re-asserted", 1'b1);
    nmi_in = 1'b1; idle(3);
    wr(8'h04, 32'h1);
    pend_is("R5", "ack after line returns high clears", 1'b0);
  endtask

  task automatic t_map;
    logic [DW-1:0] v0, v1;
    rd(8'h0C, v0, v1); chk("R9", "unmapped 0x0C reads zero", v0, 32'h0);
    rd(8'h10, v0, v1); chk("R9", "unmapped 0x10 reads zero", v0, 32'h0);
    wr(8'h0C, 32'hFFFF_FFFF);
    rd(8'h00, v0, v1); chk("R9", "unmapped write leaves ctrl", v0, 32'h0);
    wr(8'h34, 32'h1);
    rd(8'h08, v0, v1);
    chk("R9", "0x34 write ignored by base map", v0, 32'h0);
    chk("R9", "0x08 unmapped in alternate map", v1, 32'h0);
    rd(8'h34, v0, v1);
    chk("R7", "alternate map enable at 0x34", v1, 32'h1);
    chk("R9", "0x34 unmapped in base map", v0, 32'h0);
  endtask

  initial begin
    idle(4);
    rst = 1'b0;
    idle(1);
    t_reset();
    t_ctrl_field();
    t_rise();
    t_fall();
    t_mask();
    t_level_high();
    t_level_low();
    t_map();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule